// File: doc/BRIEF.md
# In-Order Retirement Checker

This block sits between a speculative core and the architected register state. The core hands it one retirement packet per instruction, in program order. Each packet holds the instruction's PC, the instruction word, the two source operand values the core used, the result or memory address, and the next PC. The checker fetches the instruction itself through its own fetch port at the PC it expects next. It reads the sources from its own eight-entry register file and recomputes the outcome with a small ALU. It then compares every core-supplied field with its own value.

The architected state is always updated with the checker's own value. When all fields agree, the instruction simply retires. On any disagreement the checker still commits its own value, raises a one-cycle flush, and presents the correct restart PC to the core. The pipeline is single-stage, in-order and blocking, with no rename or reordering. Four saturating counters keep separate mismatch tallies for the PC, the instruction word, the operands and the outcome.

Instruction word (16 bits): opcode in bits 15:13, destination in 12:10, first source in 9:7, second source in 6:4, and a signed 7-bit immediate in 6:0. The immediate overlaps the second source field.

Top module: `retire_checker`

## Requirements
- R1: A packet is accepted on a clock edge where `pkt_valid` and `pkt_ready` are high and `flush` is low. Exactly one cycle later, `ret_valid` is high for one cycle. `pkt_ready` is low while reset is asserted and for the first cycle after it; in that time no packet retires.
- R2: The checker's expected PC is shown on `imem_addr`. It starts at RESET_PC (0) after reset and afterwards always equals the checker's own next PC of the last accepted packet. If `pkt_pc` differs from it, the packet faults and the PC counter increments.
- R3: If `pkt_insn` differs from `imem_rdata`, the packet faults and the instruction counter increments. The checker decodes and executes `imem_rdata`, never `pkt_insn`.
- R4: Opcodes 0 to 5 read the first source, and opcodes 0 to 3 also read the second source. The checker compares `pkt_src1` and `pkt_src2` with its register file only for the sources the opcode reads. A mismatch faults the packet and increments the operand counter. An unread source value has no effect.
- R5: Opcode semantics, where s1/s2 are register values, imm is the sign-extended immediate, and the default next PC is pc+1:
  - 0 is s1+s2, 1 is s1-s2, 2 is s1&s2, 3 is s1|s2. Each writes the destination register.
  - 4 is a branch. Its result is pc+imm, and its next PC is pc+imm when bit 15 of s1 is set, otherwise pc+1.
  - 5 gives the address s1+imm, with no write.
  - 6 writes imm to the destination register.
  - 7 has result 0 and no write.
- R6: If `pkt_result` or `pkt_next_pc` differs from the recomputed value, the packet faults and the outcome counter increments.
- R7: Every accepted writing instruction writes the checker's own result, whether or not it faulted. This is reported one cycle later on `wb_en`/`wb_idx`/`wb_data`. Register 0 is never written (`wb_en` stays low) and always reads as zero.
- R8: A faulting packet raises `flush` for exactly one cycle, one cycle after acceptance, together with `ret_fault`. During that cycle `restart_pc` holds the checker's correct next PC.
- R9: A valid packet offered during the flush cycle is discarded. It does not retire, write, count or move the expected PC.
- R10: The four counters are independent and saturate at their maximum value. A single packet may increment more than one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | DW | Checker's expected PC, used as its fetch address |
| imem_rdata | input | 16 | Checker's own fetched instruction word at `imem_addr` |
| pkt_valid | input | 1 | Retirement packet present |
| pkt_ready | output | 1 | Checker can accept a packet |
| pkt_pc | input | DW | Core's PC for the instruction |
| pkt_insn | input | 16 | Core's instruction word |
| pkt_src1 | input | DW | Core's first source value |
| pkt_src2 | input | DW | Core's second source value |
| pkt_result | input | DW | Core's result or memory address |
| pkt_next_pc | input | DW | Core's next PC |
| ret_valid | output | 1 | An instruction retired last cycle |
| ret_fault | output | 1 | That instruction had a mismatch |
| wb_en | output | 1 | Architected register write performed |
| wb_idx | output | 3 | Register written |
| wb_data | output | DW | Value written (the checker's own) |
| flush | output | 1 | One-cycle core flush request |
| restart_pc | output | DW | PC the core must restart from |
| err_pc_cnt | output | CNT_W | PC mismatch count |
| err_insn_cnt | output | CNT_W | Instruction word mismatch count |
| err_opnd_cnt | output | CNT_W | Operand mismatch count |
| err_out_cnt | output | CNT_W | Result / next-PC mismatch count |

## Verification
The bench sweeps every opcode against every kind of field corruption, with random register choices. It targets these corners:

- A corrupted second operand on a single-source opcode must not fault. A design that compared it blindly would flush healthy instructions.
- A packet offered in the flush cycle must vanish. A design that accepted it would retire a stale instruction and move the expected PC.
- Writes to register 0 must leave it reading zero. A design that got this wrong would later report operand faults on correct packets.
- The counters run with a 4-bit width so the sweep drives them past saturation. A design that wrapped would fall back to small values.
- Branches are exercised on both sides of the sign bit, so an inverted condition shows up as a wrong restart PC.

// File: rtl/rchk_pkg.sv
// Shared types for the retirement checker: opcode encoding, decoded
// instruction fields and mismatch category indices.
// Assumes a fixed 16-bit instruction word and eight architected registers.
package rchk_pkg;

    localparam int ILEN     = 16;
    localparam int NCAT     = 4;
    localparam int CAT_PC   = 0;
    localparam int CAT_INSN = 1;
    localparam int CAT_OPND = 2;
    localparam int CAT_OUT  = 3;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_BRN = 3'd4,
        OP_MEM = 3'd5,
        OP_LDI = 3'd6,
        OP_NOP = 3'd7
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [2:0] rd;
        logic [2:0] rs1;
        logic [2:0] rs2;
        logic [6:0] imm;
    } dec_t;

    // Split an instruction word into its fields (imm overlaps rs2).
    function automatic dec_t decode(input logic [ILEN-1:0] w);
        dec_t d;
        d.op  = op_e'(w[15:13]);
        d.rd  = w[12:10];
        d.rs1 = w[9:7];
        d.rs2 = w[6:4];
        d.imm = w[6:0];
        return d;
    endfunction

endpackage

// File: rtl/rchk_regfile.sv
// Architected register file of the checker: two combinational read ports,
// one write port. Entry 0 is cleared at reset and never written, so it
// always reads zero. Assumes NREG is a power of two.
module rchk_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);

    logic [DW-1:0] mem [NREG];

    // Clear on reset; commit a write unless it targets entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we && (waddr != '0)) begin
            mem[waddr] <= wdata;
        end
    end

    // Plain reads; zero for entry 0 comes from the storage itself.
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    a_r7_zero_read_a: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_a == '0) |-> (rdata_a == '0));
    a_r7_zero_read_b: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_b == '0) |-> (rdata_b == '0));

endmodule

// File: rtl/rchk_alu.sv
// Recomputation unit: from the checker's own decoded instruction and
// register values it produces the result (or address or branch target),
// the next PC, whether the destination is written and which sources are read.
// Assumes DW > 7 so the immediate can be sign-extended.
module rchk_alu import rchk_pkg::*; #(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] pc,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [6:0]    imm,
    output logic [DW-1:0] result,
    output logic [DW-1:0] next_pc,
    output logic          wr_en,
    output logic          use_a,
    output logic          use_b
);

    logic [DW-1:0] imm_x;
    logic [DW-1:0] pc_inc;
    logic [DW-1:0] target;

    assign imm_x  = {{(DW-7){imm[6]}}, imm};
    assign pc_inc = pc + DW'(1);
    assign target = pc + imm_x;

    // Per-opcode result, next PC and source/destination usage.
    always_comb begin
        result  = '0;
        next_pc = pc_inc;
        wr_en   = 1'b0;
        use_a   = 1'b0;
        use_b   = 1'b0;
        unique case (op)
            OP_ADD: begin result = a + b; wr_en = 1'b1; use_a = 1'b1; use_b = 1'b1; end
            OP_SUB: begin result = a - b; wr_en = 1'b1; use_a = 1'b1; use_b = 1'b1; end
            OP_AND: begin result = a & b; wr_en = 1'b1; use_a = 1'b1; use_b = 1'b1; end
            OP_OR:  begin result = a | b; wr_en = 1'b1; use_a = 1'b1; use_b = 1'b1; end
            OP_BRN: begin
                result = target;
                use_a  = 1'b1;
                if (a[DW-1]) next_pc = target;
            end
            OP_MEM: begin result = a + imm_x; use_a = 1'b1; end
            OP_LDI: begin result = imm_x; wr_en = 1'b1; end
            OP_NOP: begin result = '0; end
        endcase
    end

endmodule

// File: rtl/rchk_errcnt.sv
// Bank of independent saturating mismatch counters, one per category.
// Assumes each inc bit is a single-cycle event.
module rchk_errcnt #(
    parameter int NCAT  = 4,
    parameter int CNT_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCAT-1:0]             inc,
    output logic [NCAT-1:0][CNT_W-1:0]  cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar g = 0; g < NCAT; g++) begin : g_cnt
        // Count one event per cycle, holding at the maximum.
        always_ff @(posedge clk) begin
            if (!rst_n)                          cnt[g] <= '0;
            else if (inc[g] && cnt[g] != CNT_MAX) cnt[g] <= cnt[g] + CNT_W'(1);
        end

        a_r10_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[g] >= $past(cnt[g]));
    end

endmodule

// File: rtl/retire_checker.sv
// In-order retirement checker. Accepts one core packet per cycle, fetches
// its own copy of the instruction at the expected PC, recomputes operands
// and outcome, commits its own value to the architected file, and on any
// mismatch requests a one-cycle flush with the correct restart PC.
// Assumes packets arrive in program order; anything offered during the
// flush cycle is dropped.
module retire_checker import rchk_pkg::*; #(
    parameter int             DW       = 16,
    parameter int             CNT_W    = 8,
    parameter logic [DW-1:0]  RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DW-1:0]     imem_addr,
    input  logic [ILEN-1:0]   imem_rdata,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [DW-1:0]     pkt_pc,
    input  logic [ILEN-1:0]   pkt_insn,
    input  logic [DW-1:0]     pkt_src1,
    input  logic [DW-1:0]     pkt_src2,
    input  logic [DW-1:0]     pkt_result,
    input  logic [DW-1:0]     pkt_next_pc,
    output logic              ret_valid,
    output logic              ret_fault,
    output logic              wb_en,
    output logic [2:0]        wb_idx,
    output logic [DW-1:0]     wb_data,
    output logic              flush,
    output logic [DW-1:0]     restart_pc,
    output logic [CNT_W-1:0]  err_pc_cnt,
    output logic [CNT_W-1:0]  err_insn_cnt,
    output logic [CNT_W-1:0]  err_opnd_cnt,
    output logic [CNT_W-1:0]  err_out_cnt
);

    localparam int NREG = 8;

    dec_t                      dec;
    logic [DW-1:0]             pc_q;
    logic                      ready_q;
    logic                      flush_q;
    logic                      accept;
    logic [DW-1:0]             rs1_val, rs2_val;
    logic [DW-1:0]             calc_res, calc_npc;
    logic                      calc_wr, use1, use2;
    logic [NCAT-1:0]           mis;
    logic                      fault;
    logic [NCAT-1:0][CNT_W-1:0] cnts;

    assign dec       = decode(imem_rdata);
    assign imem_addr = pc_q;
    assign pkt_ready = ready_q;
    assign flush     = flush_q;
    assign accept    = pkt_valid && ready_q && !flush_q;

    rchk_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (dec.rs1),
        .raddr_b (dec.rs2),
        .rdata_a (rs1_val),
        .rdata_b (rs2_val),
        .we      (accept && calc_wr),
        .waddr   (dec.rd),
        .wdata   (calc_res)
    );

    rchk_alu #(.DW(DW)) u_alu (
        .op      (dec.op),
        .pc      (pc_q),
        .a       (rs1_val),
        .b       (rs2_val),
        .imm     (dec.imm),
        .result  (calc_res),
        .next_pc (calc_npc),
        .wr_en   (calc_wr),
        .use_a   (use1),
        .use_b   (use2)
    );

    // Compare each core-supplied field with the checker's own value.
    always_comb begin
        mis           = '0;
        mis[CAT_PC]   = (pkt_pc != pc_q);
        mis[CAT_INSN] = (pkt_insn != imem_rdata);
        mis[CAT_OPND] = (use1 && (pkt_src1 != rs1_val)) ||
                        (use2 && (pkt_src2 != rs2_val));
        mis[CAT_OUT]  = (pkt_result != calc_res) || (pkt_next_pc != calc_npc);
    end

    assign fault = |mis;

    rchk_errcnt #(.NCAT(NCAT), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (accept ? mis : '0),
        .cnt   (cnts)
    );

    assign err_pc_cnt   = cnts[CAT_PC];
    assign err_insn_cnt = cnts[CAT_INSN];
    assign err_opnd_cnt = cnts[CAT_OPND];
    assign err_out_cnt  = cnts[CAT_OUT];

    // Retire state: expected PC, handshake, flush and writeback report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q       <= RESET_PC;
            ready_q    <= 1'b0;
            flush_q    <= 1'b0;
            ret_valid  <= 1'b0;
            ret_fault  <= 1'b0;
            wb_en      <= 1'b0;
            wb_idx     <= '0;
            wb_data    <= '0;
            restart_pc <= RESET_PC;
        end else begin
            ready_q   <= 1'b1;
            ret_valid <= accept;
            ret_fault <= accept && fault;
            flush_q   <= accept && fault;
            wb_en     <= accept && calc_wr && (dec.rd != '0);
            if (accept) begin
                pc_q    <= calc_npc;
                wb_idx  <= dec.rd;
                wb_data <= calc_res;
                if (fault) restart_pc <= calc_npc;
            end
        end
    end

    a_r1_accept_retires: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ret_valid);
    a_r1_stall_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_ready |=> !ret_valid);
    a_r8_flush_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);
    a_r8_restart_matches_pc: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (imem_addr == restart_pc));
    a_r9_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!ret_valid && $stable(imem_addr)));

endmodule

// File: tb/retire_checker_bench.sv
`timescale 1ns/1ps
module retire_checker_bench;

    localparam int DW    = 16;
    localparam int CW    = 4;
    localparam int CMAX  = 15;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [DW-1:0]  imem_addr;
    logic [15:0]    imem_rdata;
    logic           pkt_valid;
    logic           pkt_ready;
    logic [DW-1:0]  pkt_pc, pkt_src1, pkt_src2, pkt_result, pkt_next_pc;
    logic [15:0]    pkt_insn;
    logic           ret_valid, ret_fault, wb_en, flush;
    logic [2:0]     wb_idx;
    logic [DW-1:0]  wb_data, restart_pc;
    logic [CW-1:0]  err_pc_cnt, err_insn_cnt, err_opnd_cnt, err_out_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [DW-1:0] m_rf [8];
    logic [DW-1:0] m_pc;
    int            m_cnt [4];

    always #5 clk = ~clk;

    retire_checker #(.DW(DW), .CNT_W(CW)) u_retire_checker (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_pc(pkt_pc),
        .pkt_insn(pkt_insn), .pkt_src1(pkt_src1), .pkt_src2(pkt_src2),
        .pkt_result(pkt_result), .pkt_next_pc(pkt_next_pc),
        .ret_valid(ret_valid), .ret_fault(ret_fault), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_data(wb_data), .flush(flush),
        .restart_pc(restart_pc), .err_pc_cnt(err_pc_cnt),
        .err_insn_cnt(err_insn_cnt), .err_opnd_cnt(err_opnd_cnt),
        .err_out_cnt(err_out_cnt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_counters(input string tag);
        check({tag, " R10 pc cnt"},   32'(err_pc_cnt),   32'(m_cnt[0]));
        check({tag, " R10 insn cnt"}, 32'(err_insn_cnt), 32'(m_cnt[1]));
        check({tag, " R10 opnd cnt"}, 32'(err_opnd_cnt), 32'(m_cnt[2]));
        check({tag, " R10 out cnt"},  32'(err_out_cnt),  32'(m_cnt[3]));
    endtask

    // kind: 0 clean, 1 pc, 2 insn, 3 src1, 4 src2, 5 result, 6 next pc
    task automatic send(input logic [15:0] insn, input int kind);
        logic [2:0]    op, rd, rs1, rs2;
        logic [DW-1:0] a, b, imm, res, nxt;
        bit            wr, u1, u2;
        bit            f_pc, f_in, f_op, f_out, fault;
        op  = insn[15:13]; rd = insn[12:10]; rs1 = insn[9:7]; rs2 = insn[6:4];
        a   = m_rf[rs1]; b = m_rf[rs2];
        imm = DW'(signed'(insn[6:0]));
        nxt = m_pc + 1; wr = 0; u1 = (op <= 5); u2 = (op <= 3);
        case (op)
            0: begin res = a + b; wr = 1; end
            1: begin res = a - b; wr = 1; end
            2: begin res = a & b; wr = 1; end
            3: begin res = a | b; wr = 1; end
            4: begin res = m_pc + imm; if (a[DW-1]) nxt = m_pc + imm; end
            5: res = a + imm;
            6: begin res = imm; wr = 1; end
            default: res = '0;
        endcase
        imem_rdata  = insn;
        pkt_pc      = m_pc;
        pkt_insn    = insn;
        pkt_src1    = a;
        pkt_src2    = b;
        pkt_result  = res;
        pkt_next_pc = nxt;
        case (kind)
            1: pkt_pc      = m_pc ^ 16'h0100;
            2: pkt_insn    = insn ^ 16'h0001;
            3: pkt_src1    = a ^ 16'h0004;
            4: pkt_src2    = b ^ 16'h0020;
            5: pkt_result  = res ^ 16'h8000;
            6: pkt_next_pc = nxt + 1;
            default: ;
        endcase
        f_pc  = (kind == 1);
        f_in  = (kind == 2);
        f_op  = (kind == 3 && u1) || (kind == 4 && u2);
        f_out = (kind == 5) || (kind == 6);
        fault = f_pc || f_in || f_op || f_out;
        check("R2 fetch address equals expected pc", 32'(imem_addr), 32'(m_pc));
        pkt_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
        if (f_pc  && m_cnt[0] < CMAX) m_cnt[0]++;
        if (f_in  && m_cnt[1] < CMAX) m_cnt[1]++;
        if (f_op  && m_cnt[2] < CMAX) m_cnt[2]++;
        if (f_out && m_cnt[3] < CMAX) m_cnt[3]++;
        check("R1 ret_valid after accept", 32'(ret_valid), 1);
        check($sformatf("R2 R3 R4 R6 ret_fault kind %0d op %0d", kind, op),
              32'(ret_fault), 32'(fault));
        check("R8 flush with fault", 32'(flush), 32'(fault));
        check("R7 wb_en", 32'(wb_en), 32'(wr && rd != 0));
        if (wr && rd != 0) begin
            check("R7 wb_idx", 32'(wb_idx), 32'(rd));
            check("R5 R7 wb_data is checker value", 32'(wb_data), 32'(res));
            m_rf[rd] = res;
        end
        m_pc = nxt;
        if (fault) check("R8 restart_pc", 32'(restart_pc), 32'(nxt));
        check("R5 R2 next expected pc", 32'(imem_addr), 32'(m_pc));
        check_counters("after packet");
        if (fault) begin
            // Offer a packet in the flush cycle; it must be dropped.
            imem_rdata  = 16'hC7FF;
            pkt_pc      = m_pc;
            pkt_insn    = 16'hC7FF;
            pkt_result  = 16'h1234;
            pkt_next_pc = 16'h0BAD;
            pkt_valid   = 1'b1;
            @(posedge clk);
            @(negedge clk);
            pkt_valid = 1'b0;
            check("R9 no retire in flush cycle", 32'(ret_valid), 0);
            check("R9 no write in flush cycle", 32'(wb_en), 0);
            check("R8 flush lasts one cycle", 32'(flush), 0);
            check("R9 pc unchanged", 32'(imem_addr), 32'(m_pc));
            check_counters("R9 flush cycle");
        end
    endtask

    initial begin
        rst_n = 1'b0; pkt_valid = 1'b1; imem_rdata = '0; pkt_pc = '0;
        pkt_insn = '0; pkt_src1 = '0; pkt_src2 = '0; pkt_result = '0; pkt_next_pc = '0;
        for (int i = 0; i < 8; i++) m_rf[i] = '0;
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        m_pc = '0;
        repeat (3) @(negedge clk);
        check("R1 ready low in reset", 32'(pkt_ready), 0);
        check("R1 no retire in reset", 32'(ret_valid), 0);
        check("R8 no flush in reset", 32'(flush), 0);
        check("R2 reset pc", 32'(imem_addr), 0);
        check_counters("reset");
        pkt_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 ready after reset", 32'(pkt_ready), 1);
        check("R1 nothing retired", 32'(ret_valid), 0);

        // Load registers with LDI (rd = 1..7) including negatives.
        for (int r = 1; r < 8; r++) send({3'd6, 3'(r), 3'd0, 7'(r * 9 - 40)}, 0);
        // R7: write to r0 is ignored, r0 reads zero.
        send({3'd6, 3'd0, 3'd0, 7'h15}, 0);
        send({3'd0, 3'd1, 3'd0, 3'd0, 4'd0}, 0);
        send({3'd0, 3'd0, 3'd0, 3'd0, 4'd0}, 3);
        // R5 branch both ways.
        send({3'd6, 3'd2, 3'd0, 7'h7F}, 0);
        send({3'd4, 3'd0, 3'd2, 7'h7C}, 0);
        send({3'd6, 3'd3, 3'd0, 7'h05}, 0);
        send({3'd4, 3'd0, 3'd3, 7'h10}, 0);
        send({3'd4, 3'd0, 3'd2, 7'h03}, 6);
        // Sweep every opcode against every corruption kind.
        for (int rep = 0; rep < 3; rep++)
            for (int op = 0; op < 8; op++)
                for (int k = 0; k < 7; k++) begin
                    send({3'(op), 13'($urandom)}, k);
                    if (k == 6) send({3'd6, 3'($urandom_range(1, 7)), 3'd0, 7'($urandom)}, 0);
                end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule